// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block is a synchronous controller for a 16-bit successive-approximation converter that has a parallel result bus. It drives three lines into the converter: a combined strobe, an active-low select and a half-word select. The strobe starts a conversion when it is low and enables the result bus when it is high. The controller also watches the converter's ready flag, which is low while a conversion is in progress. A one-cycle start request launches exactly one conversion. The controller then waits for the ready flag to fall and rise again. After that it reads the result either as one 16-bit word or as two bytes taken from a single 8-bit lane.

Each finished sample appears as a two's complement word together with an offset-binary copy, and a one-cycle valid strobe marks it. Every timing limit is a parameter counted in clock cycles. These limits are the strobe-to-select setup, the conversion pulse width, the bus access delay, the minimum interval between conversion starts and the time allowed for ready to return. A second parameter sets a reduced-pin variant. In that variant the select line is tied low, so the strobe alone starts conversions and opens the bus.

Top module: `adc_seq_ctrl`

## Requirements
- R1: During and after synchronous reset the outputs are as follows. Strobe is high, select is inactive (high, or low in reduced-pin mode), half select is low, and valid and the timeout error are low. The overrun flag is low, and the sample and offset-binary outputs are zero.
- R2: In normal mode the controller drives the strobe low SETUP_CYC cycles before select goes low. Strobe and select are then both low for exactly PULSE_CYC cycles. Select never falls in a cycle in which the strobe changes.
- R3: A result is captured only after ready has been seen low and then high again. In normal mode the bus is never enabled (strobe high with select low) while ready is low.
- R4: In full-word mode (byte_mode_i = 0 when the start is accepted), half select stays low. All 16 bus bits are taken ACCESS_CYC cycles after select falls for the read.
- R5: In byte mode (byte_mode_i = 1) the controller reads only bus bits 7..0. It first reads with half select low, which gives result bits 7..0. It then reads with half select high, which gives result bits 15..8. Each read waits ACCESS_CYC cycles. Half select is high only while the bus is enabled.
- R6: sample_valid_o is high for exactly one cycle per conversion. In that cycle sample_o holds the converter's 16-bit two's complement result.
- R7: sample_ob_o equals sample_o with bit 15 inverted. For example, 0x7FFF gives 0xFFFF, 0x0000 gives 0x8000, 0xFFFF gives 0x7FFF and 0x8000 gives 0x0000.
- R8: A start request arriving fewer than THRU_CYC cycles after the previous strobe fall is ignored while the controller is idle. It produces no strobe edge and does not set overrun.
- R9: A start request that arrives while a conversion or read is in progress sets overrun_o. The flag stays high until reset, and the conversion in progress still delivers its correct result.
- R10: If ready has not risen again within TIMEOUT_CYC cycles of the start of the conversion pulse, the controller does the following. It raises timeout_err_o for one cycle, returns strobe and select to idle and delivers no sample. It accepts the next start normally.
- R11: With REDUCED_PIN = 1, select is held low at all times. Conversions and reads are driven by the strobe alone and return correct results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to start a conversion |
| byte_mode_i | input | 1 | Read as two bytes (1) or one word (0); sampled when a start is accepted |
| adc_strobe_o | output | 1 | Low: convert; high: bus enable (with select low) |
| adc_sel_n_o | output | 1 | Active-low converter select |
| adc_half_o | output | 1 | Half select; low gives bits 7..0 on the low lane, high gives bits 15..8 |
| adc_rdy_i | input | 1 | Converter ready flag, low during conversion |
| adc_data_i | input | 16 | Converter parallel result bus |
| sample_o | output | 16 | Last result, two's complement |
| sample_ob_o | output | 16 | Last result, offset binary |
| sample_valid_o | output | 1 | One-cycle strobe for a new sample |
| overrun_o | output | 1 | Sticky flag for a start during a busy conversion |
| timeout_err_o | output | 1 | One-cycle pulse when ready fails to return in time |

## Verification
The bench runs a converter model. When the bus is disabled the model drives a fixed wrong pattern, and it swaps its byte lanes the way half select demands. A design that reads outside the enable window therefore returns the wrong word, and so does one that picks the wrong lane or swaps the byte order. Extreme codes (0x7FFF, 0x8000, 0x0000, 0xFFFF) expose an offset-binary copy that flips the wrong bit. A start placed just after a sample catches a design that ignores the throughput interval or that wrongly flags it as overrun. A start placed during a conversion catches a design that lets it corrupt the running capture or that clears the sticky flag. A stalled converter catches a design that hangs, repeats the error pulse or emits a stale sample. A reduced-pin instance catches a design that releases select.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    localparam int SAMPLE_W = 16;
    localparam int LANE_W   = 8;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SETUP  = 3'd1,
        ST_PULSE  = 3'd2,
        ST_WAIT   = 3'd3,
        ST_ACC_LO = 3'd4,
        ST_ACC_HI = 3'd5,
        ST_DONE   = 3'd6
    } seq_state_e;

    typedef enum logic [1:0] {
        CAP_NONE = 2'd0,
        CAP_WORD = 2'd1,
        CAP_LO   = 2'd2,
        CAP_HI   = 2'd3
    } cap_op_e;

    typedef struct packed {
        logic strobe;
        logic sel_n;
        logic half;
    } adc_ctl_t;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int cnt_bits(input int v);
        return (v < 2) ? 1 : $clog2(v + 1);
    endfunction

    // two's complement to offset binary: flip the sign bit
    function automatic logic [SAMPLE_W-1:0] to_offset_bin(input logic [SAMPLE_W-1:0] w);
        return {~w[SAMPLE_W-1], w[SAMPLE_W-2:0]};
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/adc_seq_capture.sv
module adc_seq_capture
    import adc_seq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  cap_op_e             cap_op,
    input  logic [SAMPLE_W-1:0] bus_i,
    input  logic                emit,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic [SAMPLE_W-1:0] sample_ob_o,
    output logic                valid_o
);
    logic [SAMPLE_W-1:0] word_q;
    logic [LANE_W-1:0]   lane;

    assign lane = bus_i[LANE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else begin
            case (cap_op)
                CAP_WORD: word_q <= bus_i;
                CAP_LO:   word_q[LANE_W-1:0] <= lane;
                CAP_HI:   word_q[SAMPLE_W-1:LANE_W] <= lane;
                default:  word_q <= word_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_o    <= '0;
            sample_ob_o <= '0;
            valid_o     <= 1'b0;
        end else begin
            valid_o <= emit;
            if (emit) begin
                sample_o    <= word_q;
                sample_ob_o <= to_offset_bin(word_q);
            end
        end
    end
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int SETUP_CYC   = 2,
    parameter int PULSE_CYC   = 8,
    parameter int ACCESS_CYC  = 17,
    parameter bit REDUCED_PIN = 1'b0,
    parameter int CNT_W       = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             byte_mode_i,
    input  logic             rdy_i,
    input  logic             ph_exp_i,
    input  logic             thr_exp_i,
    input  logic             tmo_exp_i,
    output logic             ph_load_o,
    output logic [CNT_W-1:0] ph_val_o,
    output logic             thr_load_o,
    output logic             tmo_load_o,
    output adc_ctl_t         ctl_o,
    output cap_op_e          cap_op_o,
    output logic             emit_o,
    output logic             overrun_o,
    output logic             err_o
);
    localparam logic             IDLE_SEL_N = REDUCED_PIN ? 1'b0 : 1'b1;
    localparam logic [CNT_W-1:0] SU_LD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] PW_LD = CNT_W'(PULSE_CYC - 1);
    localparam logic [CNT_W-1:0] AC_LD = CNT_W'(ACCESS_CYC - 1);

    seq_state_e state_q, state_d;
    logic       saw_low_q;
    logic       bmode_q;
    logic       rdy_back;
    logic       accept;

    assign rdy_back = saw_low_q && rdy_i;
    assign accept   = (state_q == ST_IDLE) && start_i && thr_exp_i;

    always_comb begin
        state_d    = state_q;
        ph_load_o  = 1'b0;
        ph_val_o   = '0;
        thr_load_o = 1'b0;
        tmo_load_o = 1'b0;
        cap_op_o   = CAP_NONE;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    thr_load_o = 1'b1;
                    ph_load_o  = 1'b1;
                    if (REDUCED_PIN) begin
                        state_d    = ST_PULSE;
                        ph_val_o   = PW_LD;
                        tmo_load_o = 1'b1;
                    end else begin
                        state_d  = ST_SETUP;
                        ph_val_o = SU_LD;
                    end
                end
            end
            ST_SETUP: begin
                if (ph_exp_i) begin
                    state_d    = ST_PULSE;
                    ph_load_o  = 1'b1;
                    ph_val_o   = PW_LD;
                    tmo_load_o = 1'b1;
                end
            end
            ST_PULSE: begin
                if (ph_exp_i) begin
                    state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (rdy_back) begin
                    state_d   = ST_ACC_LO;
                    ph_load_o = 1'b1;
                    ph_val_o  = AC_LD;
                end else if (tmo_exp_i) begin
                    state_d = ST_IDLE;
                end
            end
            ST_ACC_LO: begin
                if (ph_exp_i) begin
                    if (bmode_q) begin
                        cap_op_o  = CAP_LO;
                        state_d   = ST_ACC_HI;
                        ph_load_o = 1'b1;
                        ph_val_o  = AC_LD;
                    end else begin
                        cap_op_o = CAP_WORD;
                        state_d  = ST_DONE;
                    end
                end
            end
            ST_ACC_HI: begin
                if (ph_exp_i) begin
                    cap_op_o = CAP_HI;
                    state_d  = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            saw_low_q <= 1'b0;
            bmode_q   <= 1'b0;
            overrun_o <= 1'b0;
            err_o     <= 1'b0;
        end else begin
            state_q <= state_d;
            err_o   <= (state_q == ST_WAIT) && !rdy_back && tmo_exp_i;
            if (state_q == ST_IDLE) begin
                saw_low_q <= 1'b0;
            end else if ((state_q == ST_PULSE || state_q == ST_WAIT) && !rdy_i) begin
                saw_low_q <= 1'b1;
            end
            if (accept) begin
                bmode_q <= byte_mode_i;
            end
            if (start_i && state_q != ST_IDLE) begin
                overrun_o <= 1'b1;
            end
        end
    end

    always_comb begin
        ctl_o  = '{strobe: 1'b1, sel_n: IDLE_SEL_N, half: 1'b0};
        emit_o = (state_q == ST_DONE);
        case (state_q)
            ST_SETUP:  ctl_o = '{strobe: 1'b0, sel_n: 1'b1, half: 1'b0};
            ST_PULSE:  ctl_o = '{strobe: 1'b0, sel_n: 1'b0, half: 1'b0};
            ST_ACC_LO: ctl_o = '{strobe: 1'b1, sel_n: 1'b0, half: 1'b0};
            ST_ACC_HI: ctl_o = '{strobe: 1'b1, sel_n: 1'b0, half: 1'b1};
            default:   ctl_o = '{strobe: 1'b1, sel_n: IDLE_SEL_N, half: 1'b0};
        endcase
    end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int SETUP_CYC   = 2,
    parameter int PULSE_CYC   = 8,
    parameter int ACCESS_CYC  = 17,
    parameter int THRU_CYC    = 2000,
    parameter int TIMEOUT_CYC = 1800,
    parameter bit REDUCED_PIN = 1'b0
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_i,
    input  logic                byte_mode_i,
    output logic                adc_strobe_o,
    output logic                adc_sel_n_o,
    output logic                adc_half_o,
    input  logic                adc_rdy_i,
    input  logic [SAMPLE_W-1:0] adc_data_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic [SAMPLE_W-1:0] sample_ob_o,
    output logic                sample_valid_o,
    output logic                overrun_o,
    output logic                timeout_err_o
);
    localparam int PH_MAX = max_of(max_of(SETUP_CYC, PULSE_CYC), ACCESS_CYC);
    localparam int CNT_W  = cnt_bits(max_of(PH_MAX, max_of(THRU_CYC, TIMEOUT_CYC)));

    logic             ph_load, thr_load, tmo_load;
    logic [CNT_W-1:0] ph_val;
    logic             ph_exp, thr_exp, tmo_exp;
    adc_ctl_t         ctl;
    cap_op_e          cap_op;
    logic             emit;

    adc_seq_fsm #(
        .SETUP_CYC  (SETUP_CYC),
        .PULSE_CYC  (PULSE_CYC),
        .ACCESS_CYC (ACCESS_CYC),
        .REDUCED_PIN(REDUCED_PIN),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .byte_mode_i(byte_mode_i),
        .rdy_i      (adc_rdy_i),
        .ph_exp_i   (ph_exp),
        .thr_exp_i  (thr_exp),
        .tmo_exp_i  (tmo_exp),
        .ph_load_o  (ph_load),
        .ph_val_o   (ph_val),
        .thr_load_o (thr_load),
        .tmo_load_o (tmo_load),
        .ctl_o      (ctl),
        .cap_op_o   (cap_op),
        .emit_o     (emit),
        .overrun_o  (overrun_o),
        .err_o      (timeout_err_o)
    );

    adc_seq_timer #(.W(CNT_W)) u_phase_tmr (
        .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .expired(ph_exp)
    );

    adc_seq_timer #(.W(CNT_W)) u_thru_tmr (
        .clk(clk), .rst(rst), .load(thr_load),
        .load_val(CNT_W'(THRU_CYC - 1)), .expired(thr_exp)
    );

    adc_seq_timer #(.W(CNT_W)) u_tmo_tmr (
        .clk(clk), .rst(rst), .load(tmo_load),
        .load_val(CNT_W'(TIMEOUT_CYC - 1)), .expired(tmo_exp)
    );

    adc_seq_capture u_cap (
        .clk        (clk),
        .rst        (rst),
        .cap_op     (cap_op),
        .bus_i      (adc_data_i),
        .emit       (emit),
        .sample_o   (sample_o),
        .sample_ob_o(sample_ob_o),
        .valid_o    (sample_valid_o)
    );

    assign adc_strobe_o = ctl.strobe;
    assign adc_sel_n_o  = ctl.sel_n;
    assign adc_half_o   = ctl.half;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
    parameter int PULSE_CYC   = 8,
    parameter int THRU_CYC    = 2000,
    parameter bit REDUCED_PIN = 1'b0,
    parameter int CW          = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        adc_strobe_o,
    input logic        adc_sel_n_o,
    input logic        adc_half_o,
    input logic        adc_rdy_i,
    input logic [15:0] sample_o,
    input logic [15:0] sample_ob_o,
    input logic        sample_valid_o,
    input logic        overrun_o,
    input logic        timeout_err_o
);
    logic          both_low, both_low_q, strobe_q;
    logic [CW-1:0] low_cnt, since_fall;

    assign both_low = !adc_strobe_o && !adc_sel_n_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            both_low_q <= 1'b0;
            strobe_q   <= 1'b1;
            low_cnt    <= '0;
            since_fall <= CW'(THRU_CYC);
        end else begin
            both_low_q <= both_low;
            strobe_q   <= adc_strobe_o;
            low_cnt    <= both_low ? low_cnt + 1'b1 : '0;
            if (strobe_q && !adc_strobe_o) begin
                since_fall <= CW'(1);
            end else if (since_fall < CW'(THRU_CYC)) begin
                since_fall <= since_fall + 1'b1;
            end
        end
    end

    // R2: conversion pulse lasts exactly PULSE_CYC cycles
    a_r2_pulse_width: assert property (@(posedge clk) disable iff (rst)
        (both_low_q && !both_low) |-> (low_cnt == CW'(PULSE_CYC)));

    // R2: select never falls together with a strobe change
    a_r2_setup: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_sel_n_o) |-> $stable(adc_strobe_o));

    // R5: half select only while the bus is enabled
    a_r5_half_in_read: assert property (@(posedge clk) disable iff (rst)
        adc_half_o |-> (adc_strobe_o && !adc_sel_n_o));

    // R6: valid is a single-cycle strobe
    a_r6_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        sample_valid_o |=> !sample_valid_o);

    // R7: offset-binary copy flips only the sign bit
    a_r7_offset_bin: assert property (@(posedge clk) disable iff (rst)
        sample_valid_o |-> ((sample_ob_o[15] != sample_o[15]) &&
                            (sample_ob_o[14:0] == sample_o[14:0])));

    // R8: strobe falls at least THRU_CYC cycles apart
    a_r8_thru_interval: assert property (@(posedge clk) disable iff (rst)
        (strobe_q && !adc_strobe_o) |-> (since_fall >= CW'(THRU_CYC)));

    // R9: overrun is sticky
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
        overrun_o |=> overrun_o);

    // R10: timeout error is one cycle long and strobe is back high
    a_r10_err_pulse: assert property (@(posedge clk) disable iff (rst)
        timeout_err_o |=> !timeout_err_o);
    a_r10_err_idle: assert property (@(posedge clk) disable iff (rst)
        timeout_err_o |-> (adc_strobe_o && !sample_valid_o));

    generate
        if (REDUCED_PIN) begin : g_reduced
            // R11: select held low
            a_r11_sel_low: assert property (@(posedge clk) disable iff (rst)
                !adc_sel_n_o);
        end else begin : g_normal
            // R3: bus never enabled while converting
            a_r3_no_read_window: assert property (@(posedge clk) disable iff (rst)
                !(adc_strobe_o && !adc_sel_n_o && !adc_rdy_i));
        end
    endgenerate
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(
    .PULSE_CYC  (PULSE_CYC),
    .THRU_CYC   (THRU_CYC),
    .REDUCED_PIN(REDUCED_PIN),
    .CW         (CNT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .adc_strobe_o  (adc_strobe_o),
    .adc_sel_n_o   (adc_sel_n_o),
    .adc_half_o    (adc_half_o),
    .adc_rdy_i     (adc_rdy_i),
    .sample_o      (sample_o),
    .sample_ob_o   (sample_ob_o),
    .sample_valid_o(sample_valid_o),
    .overrun_o     (overrun_o),
    .timeout_err_o (timeout_err_o)
);

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps

module adc_bhv_model #(
    parameter int CONV_CYC = 20
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        strobe,
    input  logic        sel_n,
    input  logic        half,
    input  logic        stall,
    input  logic [15:0] next_word,
    output logic        rdy,
    output logic [15:0] bus
);
    logic        go, armed_q, conv_q;
    logic [15:0] out_q;
    int          cnt_q;

    assign go = !strobe && !sel_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            conv_q  <= 1'b0;
            rdy     <= 1'b1;
            out_q   <= 16'h0000;
            cnt_q   <= 0;
        end else begin
            armed_q <= go;
            if (go && !armed_q && !conv_q && !stall) begin
                conv_q <= 1'b1;
                cnt_q  <= 0;
                rdy    <= 1'b0;
            end else if (conv_q) begin
                if (cnt_q == CONV_CYC - 1) begin
                    conv_q <= 1'b0;
                    rdy    <= 1'b1;
                    out_q  <= next_word;
                end else begin
                    cnt_q <= cnt_q + 1;
                end
            end
        end
    end

    // half high swaps lanes: low lane then carries bits 15..8
    assign bus = (strobe && !sel_n) ? (half ? {out_q[7:0], out_q[15:8]} : out_q)
                                    : 16'h0BAD;
endmodule

module adc_seq_ctrl_tb;
    localparam int SU   = 2;
    localparam int PW   = 8;
    localparam int ACC  = 4;
    localparam int THRU = 64;
    localparam int TMO  = 48;
    localparam int CONV = 20;

    // {word, byte_mode, expected offset binary}
    localparam logic [32:0] VEC [0:5] = '{
        {16'h7FFF, 1'b0, 16'hFFFF},
        {16'h0000, 1'b1, 16'h8000},
        {16'hFFFF, 1'b0, 16'h7FFF},
        {16'h8000, 1'b1, 16'h0000},
        {16'h1234, 1'b1, 16'h9234},
        {16'hA5C3, 1'b0, 16'h25C3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // main instance
    logic        start = 1'b0, bmode = 1'b0, stall = 1'b0;
    logic [15:0] nxt = 16'h0;
    logic        strobe, sel_n, half, rdy, valid, ovr, err;
    logic [15:0] bus, smp, smp_ob;

    adc_seq_ctrl #(
        .SETUP_CYC(SU), .PULSE_CYC(PW), .ACCESS_CYC(ACC),
        .THRU_CYC(THRU), .TIMEOUT_CYC(TMO), .REDUCED_PIN(1'b0)
    ) u_dut (
        .clk(clk), .rst(rst), .start_i(start), .byte_mode_i(bmode),
        .adc_strobe_o(strobe), .adc_sel_n_o(sel_n), .adc_half_o(half),
        .adc_rdy_i(rdy), .adc_data_i(bus),
        .sample_o(smp), .sample_ob_o(smp_ob), .sample_valid_o(valid),
        .overrun_o(ovr), .timeout_err_o(err)
    );

    adc_bhv_model #(.CONV_CYC(CONV)) u_adc (
        .clk(clk), .rst(rst), .strobe(strobe), .sel_n(sel_n), .half(half),
        .stall(stall), .next_word(nxt), .rdy(rdy), .bus(bus)
    );

    // reduced-pin instance
    logic        start_rp = 1'b0, bmode_rp = 1'b0;
    logic [15:0] nxt_rp = 16'h0;
    logic        strobe_rp, sel_n_rp, half_rp, rdy_rp, valid_rp, ovr_rp, err_rp;
    logic [15:0] bus_rp, smp_rp, smp_ob_rp;

    adc_seq_ctrl #(
        .SETUP_CYC(SU), .PULSE_CYC(PW), .ACCESS_CYC(ACC),
        .THRU_CYC(THRU), .TIMEOUT_CYC(TMO), .REDUCED_PIN(1'b1)
    ) u_dut_rp (
        .clk(clk), .rst(rst), .start_i(start_rp), .byte_mode_i(bmode_rp),
        .adc_strobe_o(strobe_rp), .adc_sel_n_o(sel_n_rp), .adc_half_o(half_rp),
        .adc_rdy_i(rdy_rp), .adc_data_i(bus_rp),
        .sample_o(smp_rp), .sample_ob_o(smp_ob_rp), .sample_valid_o(valid_rp),
        .overrun_o(ovr_rp), .timeout_err_o(err_rp)
    );

    adc_bhv_model #(.CONV_CYC(CONV)) u_adc_rp (
        .clk(clk), .rst(rst), .strobe(strobe_rp), .sel_n(sel_n_rp), .half(half_rp),
        .stall(1'b0), .next_word(nxt_rp), .rdy(rdy_rp), .bus(bus_rp)
    );

    // monitors, sampled away from the active edge
    logic strobe_p = 1'b1, sel_p = 1'b1, err_p = 1'b0, both_p = 1'b0;
    int   falls = 0, setup_bad = 0, win_bad = 0, err_cnt = 0, err_long = 0;
    int   valid_cnt = 0, run = 0, last_pw = 0, rp_sel_bad = 0;
    logic seen_half = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            if (strobe_p && !strobe) falls++;
            if (sel_p && !sel_n && (strobe != strobe_p)) setup_bad++;
            if (strobe && !sel_n && !rdy) win_bad++;
            if (err) err_cnt++;
            if (err && err_p) err_long++;
            if (valid) valid_cnt++;
            if (half) seen_half = 1'b1;
            if (!strobe && !sel_n) run++;
            else if (both_p) begin last_pw = run; run = 0; end
            if (sel_n_rp) rp_sel_bad++;
        end
        strobe_p = strobe;
        sel_p    = sel_n;
        err_p    = err;
        both_p   = !strobe && !sel_n;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic launch(input logic [15:0] w, input logic bm, input bit rp);
        @(negedge clk);
        if (rp) begin nxt_rp = w; bmode_rp = bm; start_rp = 1'b1; end
        else begin nxt = w; bmode = bm; start = 1'b1; end
        @(negedge clk);
        start = 1'b0;
        start_rp = 1'b0;
    endtask

    task automatic await_valid(input bit rp, output bit got);
        got = 1'b0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (rp ? valid_rp : valid) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit got;
        int f0, v0;

        // R1 reset state
        repeat (4) @(negedge clk);
        chk("R1 strobe", {31'd0, strobe}, 32'd1);
        chk("R1 sel_n", {31'd0, sel_n}, 32'd1);
        chk("R1 half", {31'd0, half}, 32'd0);
        chk("R1 valid", {31'd0, valid}, 32'd0);
        chk("R1 overrun", {31'd0, ovr}, 32'd0);
        chk("R1 err", {31'd0, err}, 32'd0);
        chk("R1 sample", {16'd0, smp}, 32'd0);
        chk("R1 sample_ob", {16'd0, smp_ob}, 32'd0);
        chk("R11 sel low in reset", {31'd0, sel_n_rp}, 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);

        // vector table: R4 R5 R6 R7
        for (int i = 0; i < 6; i++) begin
            seen_half = 1'b0;
            v0 = valid_cnt;
            launch(VEC[i][32:17], VEC[i][16], 1'b0);
            await_valid(1'b0, got);
            chk("R6 valid seen", {31'd0, got}, 32'd1);
            chk(VEC[i][16] ? "R5 byte word" : "R4 full word", {16'd0, smp}, {16'd0, VEC[i][32:17]});
            chk("R7 offset binary", {16'd0, smp_ob}, {16'd0, VEC[i][15:0]});
            chk(VEC[i][16] ? "R5 half used" : "R4 half idle", {31'd0, seen_half}, {31'd0, VEC[i][16]});
            @(negedge clk);
            chk("R6 one valid", valid_cnt - v0, 32'd1);
            chk("R2 pulse width", last_pw, PW);
            repeat (THRU) @(negedge clk);
        end
        chk("R2 select setup", setup_bad, 32'd0);
        chk("R3 no read while converting", win_bad, 32'd0);

        // R8 start inside throughput interval is ignored
        launch(16'h0F0F, 1'b0, 1'b0);
        await_valid(1'b0, got);
        f0 = falls;
        launch(16'h7777, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        chk("R8 no strobe fall", falls - f0, 32'd0);
        chk("R8 no overrun", {31'd0, ovr}, 32'd0);
        chk("R8 strobe idle", {31'd0, strobe}, 32'd1);
        repeat (THRU) @(negedge clk);
        launch(16'h3C3C, 1'b0, 1'b0);
        await_valid(1'b0, got);
        chk("R8 later start accepted", {16'd0, smp}, 32'h3C3C);

        // R9 start during conversion
        repeat (THRU) @(negedge clk);
        launch(16'h4321, 1'b1, 1'b0);
        repeat (4) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        await_valid(1'b0, got);
        chk("R9 result intact", {16'd0, smp}, 32'h4321);
        chk("R9 overrun set", {31'd0, ovr}, 32'd1);
        repeat (THRU) @(negedge clk);
        chk("R9 overrun sticky", {31'd0, ovr}, 32'd1);

        // R10 timeout on a stalled converter
        stall = 1'b1;
        v0 = valid_cnt;
        f0 = err_cnt;
        launch(16'h1111, 1'b0, 1'b0);
        repeat (SU + PW + TMO + 10) @(negedge clk);
        chk("R10 one error pulse", err_cnt - f0, 32'd1);
        chk("R10 pulse width", err_long, 32'd0);
        chk("R10 no sample", valid_cnt - v0, 32'd0);
        chk("R10 lines idle", {30'd0, strobe, sel_n}, 32'd3);
        stall = 1'b0;
        repeat (THRU) @(negedge clk);
        launch(16'h5A5A, 1'b0, 1'b0);
        await_valid(1'b0, got);
        chk("R10 recovery", {16'd0, smp}, 32'h5A5A);

        // R11 reduced-pin instance
        launch(16'hC001, 1'b1, 1'b1);
        await_valid(1'b1, got);
        chk("R11 sample", {16'd0, smp_rp}, 32'hC001);
        chk("R11 offset binary", {16'd0, smp_ob_rp}, 32'h4001);
        launch(16'h00FF, 1'b0, 1'b1);
        await_valid(1'b1, got);
        chk("R11 ignored start", {31'd0, got}, 32'd0);
        repeat (THRU) @(negedge clk);
        launch(16'h00FF, 1'b0, 1'b1);
        await_valid(1'b1, got);
        chk("R11 full word", {16'd0, smp_rp}, 32'h00FF);
        chk("R11 select held low", rp_sel_bad, 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule